// File: doc/BRIEF.md
# Single-Wire Error-Signalling Serial Transceiver

This block is a half-duplex asynchronous transceiver for a link where the transmit and receive functions share one open-drain wire, as in contact smart-card interfaces. Each character on the wire has four parts: a low start bit, eight data bits sent least significant bit first without inversion, an even-parity bit, and a stop bit. The duration of one bit is set by an 8-bit divisor `n`. One bit lasts `16*(n+1)` clock cycles, and each bit is split into sixteen sub-bit ticks.

The parity check also works as a handshake. A receiver that finds an even-parity violation holds the wire low for the whole stop-bit period. The transmitting side reads the wire in the middle of its stop bit. If the wire is low there, the transmitter records that its character was rejected. The block takes bytes through a one-deep transmit buffer and shows the last received byte on a parallel output. It raises sticky transmit-done and receive-done interrupt flags, each cleared by a pulse on its clear input. The block never drives the wire high. It only requests a low through `line_drive_low`, and the board pull-up together with any other driver forms a wired-AND that the block reads back on `line_in`.

Top module: `scu_smartcard_uart`

## Requirements
- R1: The transmitted character is a low start bit, then data bits 0 to 7 in ascending order at their true levels, then a parity bit equal to the XOR of the eight data bits, then a high stop bit. A low level is `line_drive_low = 1`.
- R2: Each bit lasts `16*(baud_div+1)` cycles. `tx_irq` reads 0 one cycle before, and 1 exactly, `176*(baud_div+1)` cycles after the first cycle in which `line_drive_low` goes high for a character.
- R3: `line_drive_low` is 1 only while the block sends a zero bit of its own character or sends a receive error pulse. It is 0 at all other times, including out of reset and during the stop bit of a character it transmits.
- R4: `tx_wr` stores `tx_byte` when `tx_buf_empty` is 1, and `tx_buf_empty` reads 0 in the next cycle. When the shifter is free, the byte moves to the shifter one cycle later: `tx_buf_empty` returns to 1 and `tx_empty` reads 0 until the character has fully shifted out. A `tx_wr` while the buffer is full is ignored.
- R5: The transmitter samples the wire in the middle of its stop bit. A low there sets `tx_err_seen`, which stays set until `err_clr`.
- R6: A falling edge on the wire starts reception only if the wire is still low at the middle of the start bit. A low shorter than half a bit produces no received byte.
- R7: Received bits are sampled at sub-tick 8 of each bit. At the end of the stop bit the byte appears on `rx_byte` and `rx_irq` sets.
- R8: On a parity violation the receiver drives the wire low for the stop-bit period and sets `rx_perr`. The byte is still delivered and `rx_irq` still sets.
- R9: `tx_irq` and `rx_irq` stay set until a pulse on `tx_irq_clr` or `rx_irq_clr`, respectively.
- R10: The receiver ignores the wire while a character is being transmitted. A buffered byte does not begin transmission until any reception in progress has finished.
- R11: After reset `tx_buf_empty` and `tx_empty` are 1, and all flags and `line_drive_low` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the bit-rate count source |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | 8 | Divisor n; bit time is 16*(n+1) cycles |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_byte | input | 8 | Byte to transmit |
| rx_byte | output | 8 | Most recently received byte |
| line_in | input | 1 | Level read back from the shared wire |
| line_drive_low | output | 1 | Open-drain request to pull the wire low |
| tx_buf_empty | output | 1 | Transmit buffer can accept a byte |
| tx_empty | output | 1 | Buffer and shifter both idle |
| tx_irq | output | 1 | Sticky transmit-complete request |
| tx_irq_clr | input | 1 | Clears tx_irq |
| rx_irq | output | 1 | Sticky receive-complete request |
| rx_irq_clr | input | 1 | Clears rx_irq |
| rx_perr | output | 1 | Sticky parity-error flag of the receiver |
| tx_err_seen | output | 1 | Sticky flag: peer signalled an error on our stop bit |
| err_clr | input | 1 | Clears rx_perr and tx_err_seen |

## Verification
The embedded properties assume that `baud_div` is held steady while a character is in flight. They also assume that `line_in` is the wired-AND of this block's own request and at most one peer. That peer never starts a character while the block is transmitting, and it releases any error pulse before the block's stop bit ends. The stimulus follows these limits. It changes the divisor only between characters. It models the wire as a pull-up ANDed with the block and a bench peer. It gives each peer character a gap long enough for the block's late-ending error pulse to finish before the next start edge.

// File: rtl/scu_pkg.sv
// Package: shared constants and types for the single-wire serial transceiver.
// Assumes the character layout is fixed: 1 start, 8 data, 1 parity, 1 stop.
package scu_pkg;
    localparam int DATA_BITS   = 8;
    localparam int FRAME_BITS  = DATA_BITS + 3;   // start + data + parity + stop
    localparam int SUB_W       = 4;               // 16 sub-bit ticks per bit
    localparam int IDX_W       = 4;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_BITS = 2'd1,
        RX_STOP = 2'd2
    } rx_state_e;
endpackage

// File: rtl/scu_tick_gen.sv
// Module: scu_tick_gen
// Divides the clock by (div+1) into sub-bit ticks and counts SUB_W bits of
// ticks per bit. It reports the bit midpoint (eighth tick) and bit end (last tick).
// Assumes div is stable while run is high; restart realigns to a bit boundary.
module scu_tick_gen #(
    parameter int DIV_W = 8,
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bit_mid,
    output logic             bit_end
);
    localparam logic [SUB_W-1:0] SUB_LAST = {SUB_W{1'b1}};
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_LAST >> 1;

    logic [DIV_W-1:0] pre_q;
    logic [SUB_W-1:0] sub_q;
    logic             tick;

    assign tick    = run && (pre_q == div);
    assign bit_mid = tick && (sub_q == SUB_MID);
    assign bit_end = tick && (sub_q == SUB_LAST);

    // Prescaler and sub-bit counter, cleared on restart or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            sub_q <= sub_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    a_r2_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pre_q <= div));
endmodule

// File: rtl/scu_tx.sv
// Module: scu_tx
// Shifts one character (start, data LSB first, even parity, stop) onto the
// open-drain request. It samples the wire in the middle of its stop bit to
// detect a receiver's error pulse. Assumes load is asserted only while idle.
module scu_tx
    import scu_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     div,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_byte,
    input  logic                 line_s,
    output logic                 busy,
    output logic                 drive_low,
    output logic                 done,
    output logic                 err_det
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shift_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  bit_mid, bit_end;

    scu_tick_gen #(.DIV_W(DIV_W), .SUB_W(SUB_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .run     (busy),
        .div     (div),
        .bit_mid (bit_mid),
        .bit_end (bit_end)
    );

    assign drive_low = busy && !shift_q[0];
    assign done      = busy && bit_end && (idx_q == LAST_IDX);
    assign err_det   = busy && bit_mid && (idx_q == LAST_IDX) && !line_s;

    // Character shifter: load a framed byte, advance one bit per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx_q   <= '0;
            shift_q <= '1;
        end else if (load) begin
            busy    <= 1'b1;
            idx_q   <= '0;
            shift_q <= {1'b1, ^load_byte, load_byte, 1'b0};
        end else if (busy && bit_end) begin
            if (idx_q == LAST_IDX) begin
                busy <= 1'b0;
            end else begin
                idx_q   <= idx_q + 1'b1;
                shift_q <= {1'b1, shift_q[FRAME_BITS-1:1]};
            end
        end
    end

    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> drive_low);
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);
    a_r3_stop_released: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx_q == LAST_IDX) |-> !drive_low);
endmodule

// File: rtl/scu_rx.sv
// Module: scu_rx
// Receives one character after a qualified start edge and checks even parity.
// On a violation it drives the wire low for the stop-bit period, then hands
// the byte over. Assumes line_s is already synchronised to clk.
module scu_rx
    import scu_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     div,
    input  logic                 enable,
    input  logic                 line_s,
    input  logic                 line_fell,
    output logic                 active,
    output logic                 drive_low,
    output logic                 done,
    output logic [DATA_BITS-1:0] byte_out,
    output logic                 perr_out
);
    localparam logic [IDX_W-1:0] PAR_IDX = IDX_W'(DATA_BITS + 1);

    rx_state_e             state_q;
    logic [IDX_W-1:0]      idx_q;
    logic [DATA_BITS-1:0]  data_q;
    logic                  par_q;
    logic                  err_q;
    logic                  start;
    logic                  bit_mid, bit_end;

    assign start     = enable && (state_q == RX_IDLE) && line_fell;
    assign active    = (state_q != RX_IDLE);
    assign drive_low = (state_q == RX_STOP) && err_q;
    assign done      = (state_q == RX_STOP) && bit_end;
    assign byte_out  = data_q;
    assign perr_out  = err_q;

    scu_tick_gen #(.DIV_W(DIV_W), .SUB_W(SUB_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (active),
        .div     (div),
        .bit_mid (bit_mid),
        .bit_end (bit_end)
    );

    // Receive sequencer: qualify start, sample mid-bit, check parity, signal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            idx_q   <= '0;
            data_q  <= '0;
            par_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                RX_IDLE: begin
                    if (start) begin
                        state_q <= RX_BITS;
                        idx_q   <= '0;
                    end
                end
                RX_BITS: begin
                    if (bit_mid) begin
                        if (idx_q == '0) begin
                            if (line_s) state_q <= RX_IDLE;
                        end else if (idx_q == PAR_IDX) begin
                            par_q <= line_s;
                        end else begin
                            data_q <= {line_s, data_q[DATA_BITS-1:1]};
                        end
                    end
                    if (bit_end) begin
                        if (idx_q == PAR_IDX) begin
                            state_q <= RX_STOP;
                            err_q   <= ^{data_q, par_q};
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (bit_end) state_q <= RX_IDLE;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    a_r6_false_start_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_BITS && idx_q == '0 && bit_mid && line_s) |=> (state_q == RX_IDLE));
    a_r8_pulse_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_STOP && !bit_end) |=> $stable(drive_low));
    a_r7_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= PAR_IDX);
endmodule

// File: rtl/scu_smartcard_uart.sv
// Module: scu_smartcard_uart (top)
// Half-duplex single-wire transceiver. It contains a one-deep transmit buffer,
// a transmit shifter and a receiver that share one open-drain line, plus the
// sticky interrupt and error flags. Assumes line_in is the wired-AND of the
// line and that baud_div only changes between characters.
module scu_smartcard_uart
    import scu_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     baud_div,
    input  logic                 tx_wr,
    input  logic [DATA_BITS-1:0] tx_byte,
    output logic [DATA_BITS-1:0] rx_byte,
    input  logic                 line_in,
    output logic                 line_drive_low,
    output logic                 tx_buf_empty,
    output logic                 tx_empty,
    output logic                 tx_irq,
    input  logic                 tx_irq_clr,
    output logic                 rx_irq,
    input  logic                 rx_irq_clr,
    output logic                 rx_perr,
    output logic                 tx_err_seen,
    input  logic                 err_clr
);
    logic                 sync1_q, line_s, line_prev;
    logic                 line_fell;
    logic                 buf_full;
    logic [DATA_BITS-1:0] buf_q;
    logic                 tx_load, tx_busy, tx_drive, tx_done, tx_err;
    logic                 rx_active, rx_drive, rx_done, rx_bad;
    logic [DATA_BITS-1:0] rx_data;

    assign line_fell      = line_prev && !line_s;
    assign tx_load        = buf_full && !tx_busy && !rx_active;
    assign tx_buf_empty   = !buf_full;
    assign tx_empty       = !buf_full && !tx_busy;
    assign line_drive_low = tx_drive || rx_drive;

    // Two-stage synchroniser plus previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q   <= 1'b1;
            line_s    <= 1'b1;
            line_prev <= 1'b1;
        end else begin
            sync1_q   <= line_in;
            line_s    <= sync1_q;
            line_prev <= line_s;
        end
    end

    // One-deep transmit buffer: accept when empty, drain into the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            buf_q    <= '0;
        end else if (tx_load) begin
            buf_full <= 1'b0;
        end else if (tx_wr && !buf_full) begin
            buf_full <= 1'b1;
            buf_q    <= tx_byte;
        end
    end

    // Sticky request and error flags; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq      <= 1'b0;
            rx_irq      <= 1'b0;
            rx_perr     <= 1'b0;
            tx_err_seen <= 1'b0;
        end else begin
            if (tx_done)         tx_irq <= 1'b1;
            else if (tx_irq_clr) tx_irq <= 1'b0;
            if (rx_done)         rx_irq <= 1'b1;
            else if (rx_irq_clr) rx_irq <= 1'b0;
            if (rx_done && rx_bad) rx_perr <= 1'b1;
            else if (err_clr)      rx_perr <= 1'b0;
            if (tx_err)            tx_err_seen <= 1'b1;
            else if (err_clr)      tx_err_seen <= 1'b0;
        end
    end

    // Received byte register, updated when a character completes.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_byte <= '0;
        else if (rx_done) rx_byte <= rx_data;
    end

    scu_tx #(.DIV_W(DIV_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (baud_div),
        .load      (tx_load),
        .load_byte (buf_q),
        .line_s    (line_s),
        .busy      (tx_busy),
        .drive_low (tx_drive),
        .done      (tx_done),
        .err_det   (tx_err)
    );

    scu_rx #(.DIV_W(DIV_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (baud_div),
        .enable    (!tx_busy && !tx_load),
        .line_s    (line_s),
        .line_fell (line_fell),
        .active    (rx_active),
        .drive_low (rx_drive),
        .done      (rx_done),
        .byte_out  (rx_data),
        .perr_out  (rx_bad)
    );

    a_r10_half_duplex: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_busy && rx_active));
    a_r9_tx_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !tx_irq_clr) |=> tx_irq);
    a_r9_rx_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !rx_irq_clr) |=> rx_irq);
    a_r5_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_seen && !err_clr) |=> tx_err_seen);
    a_r4_load_frees_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> (tx_buf_empty && !tx_empty));
    a_r3_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_drive && rx_drive));
endmodule

// File: tb/scu_smartcard_uart_tb.sv
// Bench: sweeps every byte value through both directions at the fastest bit
// rate, then checks slower rates, false starts, buffering and half-duplex order.
module scu_smartcard_uart_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] baud_div = 8'd0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_byte = 8'd0;
    logic [7:0] rx_byte;
    logic       line_drive_low, tx_buf_empty, tx_empty;
    logic       tx_irq, rx_irq, rx_perr, tx_err_seen;
    logic       tx_irq_clr = 1'b0, rx_irq_clr = 1'b0, err_clr = 1'b0;
    logic       peer_low = 1'b0;
    logic       line_w;
    int         tests = 0;
    int         fails = 0;

    always #5 clk = ~clk;
    assign line_w = ~(line_drive_low | peer_low);

    scu_smartcard_uart u_dut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .rx_byte(rx_byte),
        .line_in(line_w), .line_drive_low(line_drive_low),
        .tx_buf_empty(tx_buf_empty), .tx_empty(tx_empty),
        .tx_irq(tx_irq), .tx_irq_clr(tx_irq_clr),
        .rx_irq(rx_irq), .rx_irq_clr(rx_irq_clr),
        .rx_perr(rx_perr), .tx_err_seen(tx_err_seen), .err_clr(err_clr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        tx_byte = b;
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr   = 1'b0;
    endtask

    // Follows one character on line_drive_low; optionally plays a rejecting peer.
    task automatic watch_tx(input logic [7:0] b, input int n, input bit inject);
        int   p = 16 * (n + 1);
        int   waited = 0;
        bit   irq_pre;
        logic [10:0] fr = {1'b1, ^b, b, 1'b0};
        while (!line_drive_low && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk("R1 start bit seen", 32'(waited < 20000), 1);
        irq_pre = tx_irq;
        for (int c = 0; c <= 11 * p; c++) begin
            if (c < 11 * p && (c % p) == p / 2)
                chk("R1 bit level", 32'(line_drive_low), 32'(!fr[c / p]));
            if (c == 11 * p - 1 && !irq_pre) chk("R2 tx_irq before end", 32'(tx_irq), 0);
            if (c == 11 * p) begin
                chk("R2 tx_irq at frame end", 32'(tx_irq), 1);
                chk("R3 released after frame", 32'(line_drive_low), 0);
            end
            peer_low = inject && c >= 10 * p + 4 * (n + 1) && c < 10 * p + 12 * (n + 1);
            if (c < 11 * p) @(negedge clk);
        end
        peer_low = 1'b0;
    endtask

    // Peer transmits one character, parity optionally corrupted.
    task automatic peer_send(input logic [7:0] b, input int n, input bit bad);
        int   p = 16 * (n + 1);
        logic [10:0] fr = {1'b1, (^b) ^ bad, b, 1'b0};
        for (int c = 0; c < 11 * p; c++) begin
            peer_low = !fr[c / p];
            if (c == 10 * p + p / 2) chk("R8 error pulse in stop bit", 32'(line_drive_low), 32'(bad));
            @(negedge clk);
        end
        peer_low = 1'b0;
        repeat (4 * (n + 1) + 8) @(negedge clk);
        chk("R7 rx_irq set", 32'(rx_irq), 1);
        chk("R7 rx_byte", 32'(rx_byte), 32'(b));
        chk("R8 rx_perr", 32'(rx_perr), 32'(bad));
    endtask

    task automatic clear_flags();
        @(negedge clk);
        tx_irq_clr = 1'b1; rx_irq_clr = 1'b1; err_clr = 1'b1;
        @(negedge clk);
        tx_irq_clr = 1'b0; rx_irq_clr = 1'b0; err_clr = 1'b0;
        chk("R9 tx_irq cleared", 32'(tx_irq), 0);
        chk("R9 rx_irq cleared", 32'(rx_irq), 0);
        chk("R9 flags cleared", 32'({rx_perr, tx_err_seen}), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R2 watchdog expired: act=0 exp=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 drive", 32'(line_drive_low), 0);
        chk("R11 buffer empty", 32'(tx_buf_empty), 1);
        chk("R11 tx empty", 32'(tx_empty), 1);
        chk("R11 flags", 32'({tx_irq, rx_irq, rx_perr, tx_err_seen}), 0);

        // Transmit sweep at n=0, error injection on a byte-dependent pattern.
        baud_div = 8'd0;
        for (int b = 0; b < 256; b++) begin
            bit inj = b[0] ^ b[3];
            write_byte(8'(b));
            chk("R4 buffer full after write", 32'(tx_buf_empty), 0);
            @(negedge clk);
            chk("R4 buffer drained", 32'(tx_buf_empty), 1);
            chk("R4 shifter busy", 32'(tx_empty), 0);
            watch_tx(8'(b), 0, inj);
            chk("R5 error signal seen", 32'(tx_err_seen), 32'(inj));
            chk("R4 tx empty at end", 32'(tx_empty), 1);
            chk("R10 own frame not received", 32'(rx_irq), 0);
            clear_flags();
        end

        // Receive sweep at n=0, every fifth byte with bad parity.
        for (int b = 0; b < 256; b++) begin
            peer_send(8'(b), 0, (b % 5) == 0);
            clear_flags();
        end

        // Slower rate: R2 timing, R5 stickiness across a clean frame.
        baud_div = 8'd3;
        write_byte(8'hA5);
        watch_tx(8'hA5, 3, 1'b1);
        chk("R5 error set at n=3", 32'(tx_err_seen), 1);
        @(negedge clk); tx_irq_clr = 1'b1; @(negedge clk); tx_irq_clr = 1'b0;
        write_byte(8'h3C);
        watch_tx(8'h3C, 3, 1'b0);
        chk("R5 error flag sticky", 32'(tx_err_seen), 1);
        clear_flags();

        // R6 glitch shorter than half a bit is not a start.
        peer_low = 1'b1;
        repeat (12) @(negedge clk);
        peer_low = 1'b0;
        repeat (11 * 64 + 20) @(negedge clk);
        chk("R6 glitch ignored", 32'(rx_irq), 0);
        chk("R6 no error pulse", 32'(line_drive_low), 0);

        // R9 receive request held without a clear.
        peer_send(8'h5A, 3, 1'b1);
        repeat (500) @(negedge clk);
        chk("R9 rx_irq held", 32'(rx_irq), 1);
        chk("R8 rx_perr held", 32'(rx_perr), 1);
        clear_flags();

        // R10 write during reception waits until reception finishes.
        baud_div = 8'd1;
        fork
            peer_send(8'hC3, 1, 1'b0);
            begin
                repeat (40) @(negedge clk);
                write_byte(8'h96);
                chk("R10 buffer held during rx", 32'(tx_buf_empty), 0);
                repeat (10) @(negedge clk);
                chk("R10 still held", 32'(tx_buf_empty), 0);
                watch_tx(8'h96, 1, 1'b0);
            end
        join
        chk("R10 received byte", 32'(rx_byte), 32'h0000_00C3);
        clear_flags();

        // R4 second write buffered, third write while full ignored.
        baud_div = 8'd0;
        fork
            begin
                watch_tx(8'h11, 0, 1'b0);
                watch_tx(8'hE7, 0, 1'b0);
            end
            begin
                write_byte(8'h11);
                @(negedge clk);
                write_byte(8'hE7);
                chk("R4 buffer full", 32'(tx_buf_empty), 0);
                write_byte(8'h42);
            end
        join
        for (int c = 0; c < 300; c++) begin
            if (line_drive_low) chk("R4 ignored write not sent", 32'(line_drive_low), 0);
            @(negedge clk);
        end
        chk("R4 idle after two frames", 32'(tx_empty), 1);
        clear_flags();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule